// File: doc/BRIEF.md
# Peak-Current Pulse-Frequency Switch Controller

This block decides, clock by clock, when the low-side switch of an inductor converter conducts. It works in pulse-frequency mode: a conduction pulse is fired only while an upstream regulation loop grants a switching permit. The pulse is then cut short by one of several digitized comparator events, and the block waits out a freewheel interval before the next pulse. The analog current sensing, the voltage comparators and the power devices sit outside; this block sees only their synchronized one-bit results.

Each conduction pulse ends on the earliest of three things: an inductor-current threshold, an overvoltage on the storage rail, or a cycle-count timeout. The current threshold is the full peak level for ordinary pulses. The first pulse after every reactivation uses the half-peak level instead. The freewheel interval has a floor in cycles and otherwise lasts until the current has decayed to the zero-cross level. A separate spacing counter keeps pulse starts from arriving faster than the permitted switching rate. A switching-active flag tells the surrounding logic when a burst of pulses is in progress.

All timing limits are parameters in clock cycles. The defaults correspond to a 100 MHz clock: a 10 µs ON cap, a 0.2 µs OFF floor and a 1 µs minimum pulse spacing.

Top module: `pfm_switch_ctrl`

## Requirements
- R1: While reset is asserted and on the first sample after its release, `gate_on` and `sw_active` are low, and the next pulse is treated as a first pulse.
- R2: A pulse begins (`gate_on` rises one clock after the sample) only when `sw_permit` was sampled high. With `sw_permit` low and no burst in progress, `gate_on` stays low whatever the comparator inputs do.
- R3: On a pulse that is not the first of a burst, sampling `ipk_hit` high while `gate_on` is high makes `gate_on` low after the next clock edge.
- R4: On the first pulse of a burst, `ihalf_hit` ends the pulse in the same way and `ipk_hit` alone does not end it.
- R5: Sampling `ovp_hit` high while `gate_on` is high makes `gate_on` low after the next clock edge, on any pulse.
- R6: `gate_on` never stays high for more than TON_MAX_CYC consecutive cycles; a pulse with no terminating event lasts exactly TON_MAX_CYC cycles.
- R7: After a pulse, `gate_on` stays low for at least TOFF_MIN_CYC cycles, and after that until `izc_hit` is sampled high.
- R8: Two successive rising edges of `gate_on` are at least PERIOD_MIN_CYC cycles apart; the OFF phase is lengthened when needed to enforce this.
- R9: If `sw_permit` is low when the OFF phase completes, no new pulse starts, the controller goes idle and the next pulse is again a first pulse. A pulse that is already in progress still ends normally.
- R10: `sw_active` rises together with the first `gate_on` of a burst, stays high through every ON and OFF phase of the burst, and falls when an OFF phase completes with `sw_permit` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sw_permit | input | 1 | Switching permit from the input regulation loop (sense above reference) |
| ipk_hit | input | 1 | Inductor current has reached the full peak threshold |
| ihalf_hit | input | 1 | Inductor current has reached half the peak threshold |
| izc_hit | input | 1 | Inductor current has decayed to the zero-cross threshold |
| ovp_hit | input | 1 | Storage rail has reached the overvoltage threshold |
| gate_on | output | 1 | Low-side switch ON command |
| sw_active | output | 1 | A switching burst is in progress |

## Verification
The bench builds the controller with TON_MAX_CYC = 12, TOFF_MIN_CYC = 3 and PERIOD_MIN_CYC = 10. With these values the ON timeout can be reached in a few cycles. The spacing limit is larger than a short pulse plus the OFF floor, so fast current events really do stretch the OFF phase, while long pulses leave it untouched. Directed sequences cover first-pulse half-peak ending, full-peak ending, overvoltage, timeout, and a permit drop in the middle of a pulse. A random stream of permit and comparator patterns then runs against a cycle model kept in the bench.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_OFF  = 2'd2
  } pfm_phase_t;

  function automatic int cnt_width(input int lim);
    return (lim > 1) ? $clog2(lim) : 1;
  endfunction

endpackage

// File: rtl/pfm_sat_cnt.sv
module pfm_sat_cnt #(
  parameter int LIM      = 4,
  parameter bit RST_FULL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic full
);
  localparam int W = pfm_pkg::cnt_width(LIM);
  localparam logic [W-1:0] TOP = W'(LIM - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  assign full = (cnt_q == TOP);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (inc && !full) begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_FULL ? TOP : '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R6 / R8: once saturated, the counter holds until cleared
  p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> full);

endmodule

// File: rtl/pfm_on_term.sv
module pfm_on_term (
  input  logic first_pulse,
  input  logic ipk_hit,
  input  logic ihalf_hit,
  input  logic ovp_hit,
  input  logic on_full,
  output logic end_on
);
  logic cur_hit;

  always_comb begin
    cur_hit = first_pulse ? ihalf_hit : ipk_hit;
    end_on  = cur_hit || ovp_hit || on_full;
  end

endmodule

// File: rtl/pfm_seq.sv
module pfm_seq
  import pfm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_permit,
  input  logic ihalf_hit,
  input  logic ovp_hit,
  input  logic izc_hit,
  input  logic end_on,
  input  logic on_full,
  input  logic off_full,
  input  logic per_full,
  output logic first_pulse,
  output logic in_on,
  output logic in_off,
  output logic start_on,
  output logic start_off,
  output logic gate_on,
  output logic sw_active
);
  pfm_phase_t ph_q, ph_d;
  logic       act_q, act_d;
  logic       first_q, first_d;

  always_comb begin
    ph_d    = ph_q;
    act_d   = act_q;
    first_d = first_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (sw_permit && per_full) begin
          ph_d  = PH_ON;
          act_d = 1'b1;
        end
      end
      PH_ON: begin
        if (end_on) begin
          ph_d    = PH_OFF;
          first_d = 1'b0;
        end
      end
      PH_OFF: begin
        if (off_full && izc_hit && per_full) begin
          if (sw_permit) begin
            ph_d = PH_ON;
          end else begin
            ph_d    = PH_IDLE;
            act_d   = 1'b0;
            first_d = 1'b1;
          end
        end
      end
      default: begin
        ph_d    = PH_IDLE;
        act_d   = 1'b0;
        first_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      act_q   <= 1'b0;
      first_q <= 1'b1;
    end else begin
      ph_q    <= ph_d;
      act_q   <= act_d;
      first_q <= first_d;
    end
  end

  assign in_on       = (ph_q == PH_ON);
  assign in_off      = (ph_q == PH_OFF);
  assign start_on    = (ph_d == PH_ON)  && (ph_q != PH_ON);
  assign start_off   = (ph_d == PH_OFF) && (ph_q != PH_OFF);
  assign gate_on     = in_on;
  assign sw_active   = act_q;
  assign first_pulse = first_q;

  // R2: a pulse only starts from a sampled permit
  p_permit_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |-> $past(sw_permit));

  // R4: half-peak ends the first pulse of a burst
  p_first_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && first_pulse && ihalf_hit) |=> !gate_on);

  // R5: overvoltage ends any pulse
  p_ovp_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && ovp_hit) |=> !gate_on);

  // R6: timeout ends the pulse
  p_ton_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && on_full) |=> !gate_on);

  // R7: no new pulse before the OFF floor has elapsed
  p_off_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_off && !off_full) |=> !gate_on);

  // R8: pulse starts respect the spacing counter
  p_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |-> $past(per_full));

  // R9: idle controller always has the first-pulse rule armed
  p_idle_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_active |-> first_pulse);

  // R10: every pulse lies inside an active burst
  p_active_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |-> sw_active);

endmodule

// File: rtl/pfm_switch_ctrl.sv
module pfm_switch_ctrl #(
  parameter int TON_MAX_CYC    = 1000,
  parameter int TOFF_MIN_CYC   = 20,
  parameter int PERIOD_MIN_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_permit,
  input  logic ipk_hit,
  input  logic ihalf_hit,
  input  logic izc_hit,
  input  logic ovp_hit,
  output logic gate_on,
  output logic sw_active
);
  logic first_pulse;
  logic in_on, in_off;
  logic start_on, start_off;
  logic on_full, off_full, per_full;
  logic end_on;

  pfm_sat_cnt #(.LIM(TON_MAX_CYC), .RST_FULL(1'b0)) u_on_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start_on),
    .inc  (in_on),
    .full (on_full)
  );

  pfm_sat_cnt #(.LIM(TOFF_MIN_CYC), .RST_FULL(1'b0)) u_off_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start_off),
    .inc  (in_off),
    .full (off_full)
  );

  pfm_sat_cnt #(.LIM(PERIOD_MIN_CYC), .RST_FULL(1'b1)) u_per_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start_on),
    .inc  (1'b1),
    .full (per_full)
  );

  pfm_on_term u_term (
    .first_pulse(first_pulse),
    .ipk_hit    (ipk_hit),
    .ihalf_hit  (ihalf_hit),
    .ovp_hit    (ovp_hit),
    .on_full    (on_full),
    .end_on     (end_on)
  );

  pfm_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_permit  (sw_permit),
    .ihalf_hit  (ihalf_hit),
    .ovp_hit    (ovp_hit),
    .izc_hit    (izc_hit),
    .end_on     (end_on),
    .on_full    (on_full),
    .off_full   (off_full),
    .per_full   (per_full),
    .first_pulse(first_pulse),
    .in_on      (in_on),
    .in_off     (in_off),
    .start_on   (start_on),
    .start_off  (start_off),
    .gate_on    (gate_on),
    .sw_active  (sw_active)
  );

endmodule

// File: tb/sim_pfm_switch_ctrl.sv
module sim_pfm_switch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TON  = 12;
  localparam int TOFF = 3;
  localparam int PMIN = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_permit = 1'b0, ipk_hit = 1'b0, ihalf_hit = 1'b0;
  logic izc_hit = 1'b0, ovp_hit = 1'b0;
  logic gate_on, sw_active;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench cycle model
  bit m_gate = 1'b0, m_act = 1'b0, m_first = 1'b1, m_off = 1'b0;
  int m_ton = 0, m_toff = 0, m_since = PMIN;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfm_switch_ctrl #(
    .TON_MAX_CYC(TON), .TOFF_MIN_CYC(TOFF), .PERIOD_MIN_CYC(PMIN)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .sw_permit(sw_permit), .ipk_hit(ipk_hit),
    .ihalf_hit(ihalf_hit), .izc_hit(izc_hit), .ovp_hit(ovp_hit),
    .gate_on(gate_on), .sw_active(sw_active)
  );

  task automatic check_bit(input logic act, input bit exp, input string tag, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit p, input bit pk, input bit hf, input bit zc, input bit ov);
    bit restart;
    restart = 1'b0;
    if (m_gate) begin
      if (ov || (m_first ? hf : pk) || (m_ton >= TON)) begin
        m_gate = 1'b0; m_off = 1'b1; m_toff = 1; m_first = 1'b0;
      end else begin
        m_ton++;
      end
    end else if (m_off) begin
      if (m_toff >= TOFF && zc && m_since >= PMIN) begin
        m_off = 1'b0;
        if (p) begin
          m_gate = 1'b1; m_ton = 1; restart = 1'b1;
        end else begin
          m_act = 1'b0; m_first = 1'b1;
        end
      end else begin
        m_toff++;
      end
    end else if (p && m_since >= PMIN) begin
      m_gate = 1'b1; m_act = 1'b1; m_ton = 1; restart = 1'b1;
    end
    if (restart) m_since = 1;
    else if (m_since < PMIN) m_since++;
  endtask

  task automatic step(input bit p, input bit pk, input bit hf, input bit zc, input bit ov,
                      input string tag);
    @(negedge clk);
    if (done) return;
    check_bit(gate_on, m_gate, tag, "gate_on");
    check_bit(sw_active, m_act, tag, "sw_active");
    sw_permit = p; ipk_hit = pk; ihalf_hit = hf; izc_hit = zc; ovp_hit = ov;
    model_step(p, pk, hf, zc, ov);
  endtask

  task automatic idle_n(input int n, input bit p, input string tag);
    for (int i = 0; i < n; i++) step(p, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1: outputs low during reset
    check_bit(gate_on, 1'b0, "R1", "gate_on in reset");
    check_bit(sw_active, 1'b0, "R1", "sw_active in reset");
    @(negedge clk);
    rst_n = 1'b1;
    idle_n(3, 1'b0, "R1");

    // R2: permit low, comparators toggling, no pulse
    for (int i = 0; i < 20; i++)
      step(1'b0, 1'(i % 2), 1'(i % 3 == 0), 1'b1, 1'(i % 5 == 0), "R2");

    // R4: first pulse ignores full peak, ends on half peak
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
    // R7 and R8: OFF floor, then spacing stretches OFF even with zc high
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    // R3: second pulse ends on full peak
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    // R7: OFF waits for zero-cross beyond the floor
    for (int i = 0; i < 15; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
    // R6: no terminating event, timeout
    for (int i = 0; i < TON + 2; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R10");
    // R5: overvoltage ends the pulse
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R5");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    // R9: permit drops mid-pulse, pulse completes, burst ends
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
    // R9 / R4: next burst starts with a half-peak pulse again
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
    idle_n(6, 1'b0, "R10");
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R10");

    // random mix against the bench model
    for (int i = 0; i < 4000; i++) begin
      bit p, pk, hf, zc, ov;
      p  = (($urandom % 8) != 0);
      hf = (($urandom % 4) == 0);
      pk = hf && (($urandom % 2) == 0);
      zc = (($urandom % 3) == 0);
      ov = (($urandom % 16) == 0);
      if ((i / 500) % 2 == 1) p = (($urandom % 3) == 0);
      step(p, pk, hf, zc, ov, "R3 R5 R7 R8 R10 random");
    end
    finish_run();
  end

endmodule